// File: doc/BRIEF.md
# Keyed Software Reset Line Controller

This block drives a bank of individual reset lines, one per on-chip subsystem, under software control. Software sets a bit in a control register to hold the matching subsystem in reset and clears the bit to let it run again. Control writes are accepted only when the upper byte of the written word carries a fixed key. A stray or corrupted write therefore cannot pulse a subsystem into reset.

A second register, the gate register, needs no key. It holds one permission bit per line. A line is driven high only while both its control bit and its gate bit are set. The intended software order has two rules. To assert a line, set its gate bit first and then set its control bit. To release a line, clear its control bit first and then clear its gate bit. The gate register can be removed by a parameter, and then only the control bits drive the lines. Both registers read back over the same bus. The reset outputs come from flops, so they change cleanly at the clock edge that accepts the write.

Top module: `srl_keyed_reset_ctrl`

## Requirements
- R1: After the asynchronous reset, all reset lines are low, and both the control register (offset 0x08) and the gate register (offset 0x0C) read 0.
- R2: A write to offset 0x08 with 0x88 in wdata[31:24] loads wdata[N_LINES-1:0] into the control bits.
- R3: A write to offset 0x08 whose wdata[31:24] is not 0x88 leaves the control bits and the reset lines unchanged.
- R4: A write to offset 0x0C loads wdata[N_LINES-1:0] into the gate bits, whatever wdata[31:24] holds.
- R5: rst_lines[n] is high exactly when control bit n and gate bit n are both set. It changes at the rising edge that accepts the write and stays steady during the cycle in which the write is presented.
- R6: Readback bits at positions N_LINES and above read 0 in both registers, including the key byte of the control register.
- R7: With the gate bit held set, clearing a control bit releases its line. With the control bit held set, clearing the gate bit also drops the line.
- R8: A write to any offset other than 0x08 or 0x0C changes neither register and no reset line. A read of such an offset returns 0.
- R9: rdata shows, without delay, the register selected by addr, and reflects any write accepted at the previous edge.
- R10: While wr_en is low, no register and no line changes, even when addr and wdata form a valid keyed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Register byte offset for write and read |
| wdata | input | DATA_W | Write data; the upper byte carries the key for control writes |
| rdata | output | DATA_W | Readback of the register selected by addr |
| rst_lines | output | N_LINES | Registered reset outputs, active high |

## Verification
The gate register is first loaded with a sparse pattern. Keyed control writes with overlapping and disjoint bit sets then show that the output is the AND of the two registers and not either one alone. A walking one across every line, with all gates open, shows that each control bit drives its own output and no neighbour. Writes whose upper byte is one bit away from the key, or is zero, are told apart from the true key, and so are keyed writes to unused offsets and keyed data with the strobe low. Writes of all ones separate the implemented bits from the padding bits in readback. The outputs are also sampled just before the accepting edge, to separate a registered output from one that follows the bus directly.

// File: rtl/srl_pkg.sv
package srl_pkg;

  // Key value that must occupy the top byte of a control write
  localparam logic [7:0] CTRL_KEY = 8'h88;

  // Register byte offsets
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_GATE = 8'h0C;

  // Decoded write strobes for one bus cycle
  typedef struct packed {
    logic ctrl_wr;
    logic gate_wr;
  } wr_dec_t;

endpackage

// File: rtl/srl_wr_decode.sv
module srl_wr_decode
  import srl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        key_byte,
  output wr_dec_t           dec
);

  logic hit_ctrl;
  logic hit_gate;
  logic key_ok;

  always_comb begin
    hit_ctrl    = (addr == ADDR_W'(OFS_CTRL));
    hit_gate    = (addr == ADDR_W'(OFS_GATE));
    key_ok      = (key_byte == CTRL_KEY);
    dec.ctrl_wr = wr_en && hit_ctrl && key_ok;
    dec.gate_wr = wr_en && hit_gate;
  end

endmodule

// File: rtl/srl_line_cell.sv
module srl_line_cell #(
  parameter bit HAS_GATE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic gate_wr,
  input  logic ctrl_in,
  input  logic gate_in,
  output logic ctrl_q,
  output logic gate_q,
  output logic line_q
);

  logic ctrl_d;
  logic gate_d;
  logic gate_eff_d;
  logic line_d;

  // Next-state logic
  always_comb begin
    ctrl_d = ctrl_wr ? ctrl_in : ctrl_q;
  end

  generate
    if (HAS_GATE) begin : g_gate
      logic gate_r;
      always_comb begin
        gate_d     = gate_wr ? gate_in : gate_r;
        gate_eff_d = gate_d;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          gate_r <= 1'b0;
        end else if (gate_wr) begin
          gate_r <= gate_d;
        end
      end
      assign gate_q = gate_r;
    end else begin : g_nogate
      always_comb begin
        gate_d     = 1'b0;
        gate_eff_d = 1'b1;
      end
      assign gate_q = gate_d;
    end
  endgenerate

  always_comb begin
    line_d = ctrl_d & gate_eff_d;
  end

  // Control register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  // Output flop: updates whenever either source register may change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
    end else if (ctrl_wr || gate_wr) begin
      line_q <= line_d;
    end
  end

endmodule

// File: rtl/srl_line_bank.sv
module srl_line_bank
  import srl_pkg::*;
#(
  parameter int N_LINES  = 24,
  parameter bit HAS_GATE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wr_dec_t            dec,
  input  logic [N_LINES-1:0] wbits,
  output logic [N_LINES-1:0] ctrl_bits,
  output logic [N_LINES-1:0] gate_bits,
  output logic [N_LINES-1:0] lines
);

  genvar i;
  generate
    for (i = 0; i < N_LINES; i++) begin : g_line
      srl_line_cell #(
        .HAS_GATE(HAS_GATE)
      ) cell_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_wr(dec.ctrl_wr),
        .gate_wr(dec.gate_wr),
        .ctrl_in(wbits[i]),
        .gate_in(wbits[i]),
        .ctrl_q (ctrl_bits[i]),
        .gate_q (gate_bits[i]),
        .line_q (lines[i])
      );
    end
  endgenerate

endmodule

// File: rtl/srl_readback.sv
module srl_readback
  import srl_pkg::*;
#(
  parameter int N_LINES = 24,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_LINES-1:0] ctrl_bits,
  input  logic [N_LINES-1:0] gate_bits,
  output logic [DATA_W-1:0]  rdata
);

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      rdata = DATA_W'(ctrl_bits);
    end else if (addr == ADDR_W'(OFS_GATE)) begin
      rdata = DATA_W'(gate_bits);
    end
  end

endmodule

// File: rtl/srl_keyed_reset_ctrl.sv
module srl_keyed_reset_ctrl
  import srl_pkg::*;
#(
  parameter int N_LINES  = 24,
  parameter bit HAS_GATE = 1'b1,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [N_LINES-1:0] rst_lines
);

  localparam int KEY_LSB = DATA_W - 8;

  wr_dec_t            dec;
  logic [N_LINES-1:0] ctrl_bits;
  logic [N_LINES-1:0] gate_bits;

  srl_wr_decode #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dec_i (
    .wr_en   (wr_en),
    .addr    (addr),
    .key_byte(wdata[KEY_LSB +: 8]),
    .dec     (dec)
  );

  srl_line_bank #(
    .N_LINES (N_LINES),
    .HAS_GATE(HAS_GATE)
  ) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (dec),
    .wbits    (wdata[N_LINES-1:0]),
    .ctrl_bits(ctrl_bits),
    .gate_bits(gate_bits),
    .lines    (rst_lines)
  );

  srl_readback #(
    .N_LINES(N_LINES),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) rb_i (
    .addr     (addr),
    .ctrl_bits(ctrl_bits),
    .gate_bits(gate_bits),
    .rdata    (rdata)
  );

endmodule

// File: rtl/srl_keyed_reset_ctrl_chk.sv
module srl_keyed_reset_ctrl_chk
  import srl_pkg::*;
#(
  parameter int N_LINES  = 24,
  parameter bit HAS_GATE = 1'b1,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic [N_LINES-1:0] rst_lines,
  input logic [N_LINES-1:0] ctrl_bits,
  input logic [N_LINES-1:0] gate_bits
);

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_CTRL) && wdata[DATA_W-1 -: 8] == CTRL_KEY)
      |=> ctrl_bits == $past(wdata[N_LINES-1:0]));

  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_CTRL) && wdata[DATA_W-1 -: 8] != CTRL_KEY)
      |=> $stable(ctrl_bits) && $stable(rst_lines));

  // R4
  gate_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_GATE && wr_en && addr == ADDR_W'(OFS_GATE))
      |=> gate_bits == $past(wdata[N_LINES-1:0]));

  // R5
  gated_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    HAS_GATE |-> (rst_lines & ~gate_bits) == '0);

  // R5
  out_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(ctrl_bits) && $stable(gate_bits)) |-> $stable(rst_lines));

  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata >> N_LINES) == '0);

  // R8
  stray_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != ADDR_W'(OFS_CTRL) && addr != ADDR_W'(OFS_GATE))
      |=> $stable(ctrl_bits) && $stable(gate_bits) && $stable(rst_lines));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_bits) && $stable(gate_bits));

endmodule

bind srl_keyed_reset_ctrl srl_keyed_reset_ctrl_chk #(
  .N_LINES (N_LINES),
  .HAS_GATE(HAS_GATE),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .rst_lines(rst_lines),
  .ctrl_bits(ctrl_bits),
  .gate_bits(gate_bits)
);

// File: tb/srl_keyed_reset_ctrl_tb_top.sv
module srl_keyed_reset_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 24;
  localparam logic [7:0] A_CTRL = 8'h08;
  localparam logic [7:0] A_GATE = 8'h0C;

  typedef struct {
    logic [NL-1:0] lines;
    logic [31:0]   rdata;
    string         req;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [7:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [NL-1:0] rst_lines;

  exp_t          sb_q[$];
  logic [NL-1:0] m_ctrl;
  logic [NL-1:0] m_gate;
  int            n_chk;
  int            n_fail;
  bit            done;

  srl_keyed_reset_ctrl #(
    .N_LINES(NL)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .rst_lines(rst_lines)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == A_CTRL) return 32'(m_ctrl);
    if (a == A_GATE) return 32'(m_gate);
    return 32'h0;
  endfunction

  // Driver: one bus cycle, model update, expected item into the scoreboard
  task automatic bus_op(input logic w, input logic [7:0] a,
                        input logic [31:0] d, input string req);
    logic [NL-1:0] old_lines;
    exp_t          it;
    old_lines = m_ctrl & m_gate;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d;
    if (w) begin
      if (a == A_CTRL && d[31:24] == 8'h88) m_ctrl = d[NL-1:0];
      if (a == A_GATE) m_gate = d[NL-1:0];
    end
    #1;
    n_chk++;
    if (rst_lines !== old_lines) begin
      n_fail++;
      $display("FAIL R5 (pre-edge, %s) lines act=%h exp=%h", req, rst_lines, old_lines);
    end
    @(posedge clk);
    it.lines = m_ctrl & m_gate;
    it.rdata = model_read(a);
    it.req   = req;
    sb_q.push_back(it);
  endtask

  // Monitor: compare results after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (rst_lines !== it.lines || rdata !== it.rdata) begin
          n_fail++;
          $display("FAIL %s lines act=%h exp=%h rdata act=%h exp=%h",
                   it.req, rst_lines, it.lines, rdata, it.rdata);
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    m_ctrl = '0; m_gate = '0;
    rst_n = 1'b0; wr_en = 1'b0; addr = 8'h00; wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of both registers and lines
    bus_op(1'b0, A_CTRL, 32'h0, "R1");
    bus_op(1'b0, A_GATE, 32'h0, "R1");

    // R4: gate written without key, read back (R9)
    bus_op(1'b1, A_GATE, 32'h0000_F0F0, "R4");
    bus_op(1'b0, A_GATE, 32'h0, "R9");

    // R2: keyed control write, lines are control AND gate (R5)
    bus_op(1'b1, A_CTRL, 32'h8800_FF00, "R2");
    bus_op(1'b0, A_CTRL, 32'h0, "R5");

    // R3: near-miss keys and a zero key are ignored
    bus_op(1'b1, A_CTRL, 32'h8900_00FF, "R3");
    bus_op(1'b1, A_CTRL, 32'h0800_00FF, "R3");
    bus_op(1'b1, A_CTRL, 32'h00FF_FFFF, "R3");
    bus_op(1'b0, A_CTRL, 32'h0, "R3");

    // R10: strobe low with a valid keyed word
    bus_op(1'b0, A_CTRL, 32'h88FF_FFFF, "R10");

    // R8: keyed writes to unused offsets, and their readback
    bus_op(1'b1, 8'h10, 32'h88FF_FFFF, "R8");
    bus_op(1'b1, 8'h18, 32'h88FF_FFFF, "R8");
    bus_op(1'b0, A_CTRL, 32'h0, "R8");

    // R6: all-ones writes, padding bits read zero
    bus_op(1'b1, A_GATE, 32'hFFFF_FFFF, "R6");
    bus_op(1'b1, A_CTRL, 32'h88FF_FFFF, "R6");

    // R7: release by control, drop by gate
    bus_op(1'b1, A_CTRL, 32'h887F_FFFF, "R7");
    bus_op(1'b1, A_GATE, 32'hFFFF_FFFE, "R7");
    bus_op(1'b1, A_CTRL, 32'h8800_0001, "R7");
    bus_op(1'b1, A_GATE, 32'h0000_0001, "R7");

    // R5: walking one across every line with all gates open
    bus_op(1'b1, A_GATE, 32'h00FF_FFFF, "R5");
    for (int i = 0; i < NL; i++) begin
      bus_op(1'b1, A_CTRL, {8'h88, NL'(1) << i}, "R5");
    end
    bus_op(1'b1, A_CTRL, 32'h8800_0000, "R5");

    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule